// File: doc/BRIEF.md
# Watchdog and Reset Supervisor

This block drives the system reset line of a chip from three causes: power application, a low-supply warning, and a watchdog that firmware has not serviced in time. A single hold-off timer stretches every reset so that supply and clock can settle before the system is let go. The low-supply condition comes in as a digital flag from an analog comparator outside the block. Power application is modelled by the synchronous reset input.

Firmware restarts the watchdog by toggling a pin that also serves as the serial-bus chip select. Only a falling edge on that pin counts, and the block synchronizes the pin to its own clock first. A two-bit selection, held outside the block in retained storage, picks one of three timeouts or turns the watchdog off. A flag that firmware can read records whether the most recent reset came from the watchdog. Firmware can clear that flag.

Top module: `rst_supervisor`

## Requirements
- R1: After the power-on reset input `rst` drops, the reset output stays asserted for HOLD_TICKS timebase ticks and is then released.
- R2: While `supply_low_i` is high, the reset output is asserted in the same cycle. After it clears, the output stays asserted for HOLD_TICKS further ticks.
- R3: When the watchdog is enabled and not restarted, the output is released for exactly the selected interval in ticks and is then asserted again. `wd_sel_i` = 2'b00 selects WD_SHORT, 2'b01 selects WD_MED and 2'b10 selects WD_LONG.
- R4: `wd_sel_i` = 2'b11 disables the watchdog, so no watchdog reset ever occurs.
- R5: A falling edge on `csn_wdi_i`, seen after SYNC_STAGES synchronizer flops, restarts the watchdog count. A rising edge or a steady level has no effect.
- R6: The watchdog count is held at zero while reset is asserted, so each release starts a full interval.
- R7: A watchdog expiry sets `wd_flag_o` (1 means the last reset came from the watchdog), and it is visible from the first cycle of that reset.
- R8: `wd_flag_o` is cleared by power-on reset, by the low-supply input, or by a one-cycle `flag_clr_i` pulse. An expiry in the same cycle as a clear wins.
- R9: With ACTIVE_HIGH = 1 the output is high while asserted. With ACTIVE_HIGH = 0 it is the exact complement.
- R10: Timers advance only in cycles with `tick_i` high, and a release or an expiry happens only on a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| tick_i | input | 1 | Timebase tick, one clock wide |
| supply_low_i | input | 1 | Low-supply comparator flag, active high |
| csn_wdi_i | input | 1 | Shared chip-select / watchdog restart pin |
| wd_sel_i | input | 2 | Watchdog interval selection from retained storage |
| flag_clr_i | input | 1 | Firmware clear of the watchdog cause flag |
| sys_rst_o | output | 1 | System reset, polarity set by ACTIVE_HIGH |
| wd_flag_o | output | 1 | 1 when the last reset came from the watchdog |

## Verification
Some properties are checked on every cycle:
- the low-supply input forces reset;
- an expiry happens only on a tick and sets the flag;
- the flag clears under low supply;
- the disabled setting never expires;
- the counter stays cleared and in range while reset is asserted.

The exact lengths of the hold-off and of each watchdog interval, the synchronizer delay before a restart takes effect, rising edges being ignored, and the relation between the two output polarities are only shown by the bench. It measures each phase length in cycles and compares it with the arithmetic expected for that setting.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

    typedef enum logic [1:0] {
        WD_SEL_SHORT = 2'b00,
        WD_SEL_MED   = 2'b01,
        WD_SEL_LONG  = 2'b10,
        WD_SEL_OFF   = 2'b11
    } wd_sel_e;

    typedef struct packed {
        logic kick;
        logic expire;
    } wd_evt_t;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic logic drive_level(input logic active, input bit high);
        return high ? active : ~active;
    endfunction

endpackage

// File: rtl/rsv_edge_sync.sv
module rsv_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    output logic fall_o
);
    logic [STAGES:0] chain;
    logic            prev_q;

    assign chain[0] = pin_i;

    generate
        for (genvar i = 1; i <= STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= 1'b1;
                else     chain[i] <= chain[i-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= chain[STAGES];
    end

    assign fall_o = prev_q & ~chain[STAGES];
endmodule

// File: rtl/rsv_hold_timer.sv
module rsv_hold_timer #(
    parameter int HOLD_TICKS = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic restart_i,
    output logic busy_o
);
    localparam int HW = $clog2(HOLD_TICKS + 1);

    logic [HW-1:0] cnt_q;
    logic          busy_q;

    always_ff @(posedge clk) begin
        if (rst || restart_i) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
        end else if (busy_q && tick_i) begin
            if (cnt_q == HW'(HOLD_TICKS - 1)) begin
                busy_q <= 1'b0;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign busy_o = busy_q;
endmodule

// File: rtl/rsv_wd_timer.sv
module rsv_wd_timer
    import rsv_pkg::*;
#(
    parameter int WD_SHORT = 5,
    parameter int WD_MED   = 10,
    parameter int WD_LONG  = 20,
    parameter int CW       = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_i,
    input  logic          hold_i,
    input  logic [1:0]    sel_i,
    input  logic          kick_i,
    output wd_evt_t       evt_o,
    output logic [CW-1:0] cnt_o
);
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] lim_m1;
    logic          off;
    logic          at_end;

    always_comb begin
        unique case (wd_sel_e'(sel_i))
            WD_SEL_SHORT: lim_m1 = CW'(WD_SHORT - 1);
            WD_SEL_MED:   lim_m1 = CW'(WD_MED - 1);
            WD_SEL_LONG:  lim_m1 = CW'(WD_LONG - 1);
            default:      lim_m1 = '0;
        endcase
    end

    assign off    = (wd_sel_e'(sel_i) == WD_SEL_OFF);
    assign at_end = (cnt_q >= lim_m1);

    always_ff @(posedge clk) begin
        if (rst || hold_i || off || kick_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= at_end ? '0 : cnt_q + 1'b1;
        end
    end

    assign evt_o.kick   = kick_i;
    assign evt_o.expire = !hold_i && !off && !kick_i && tick_i && at_end;
    assign cnt_o        = cnt_q;
endmodule

// File: rtl/rsv_cause_flag.sv
module rsv_cause_flag (
    input  logic clk,
    input  logic rst,
    input  logic low_i,
    input  logic expire_i,
    input  logic clr_i,
    output logic flag_o
);
    always_ff @(posedge clk) begin
        if (rst)           flag_o <= 1'b0;
        else if (low_i)    flag_o <= 1'b0;
        else if (expire_i) flag_o <= 1'b1;
        else if (clr_i)    flag_o <= 1'b0;
    end
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor
    import rsv_pkg::*;
#(
    parameter bit ACTIVE_HIGH = 1'b1,
    parameter int HOLD_TICKS  = 6,
    parameter int WD_SHORT    = 5,
    parameter int WD_MED      = 10,
    parameter int WD_LONG     = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_i,
    input  logic       supply_low_i,
    input  logic       csn_wdi_i,
    input  logic [1:0] wd_sel_i,
    input  logic       flag_clr_i,
    output logic       sys_rst_o,
    output logic       wd_flag_o
);
    localparam int WD_MAX = max3(WD_SHORT, WD_MED, WD_LONG);
    localparam int WD_CW  = $clog2(WD_MAX + 1);

    logic             kick;
    logic             hold_busy;
    logic             rst_active;
    logic             wd_expire;
    wd_evt_t          wd_evt;
    logic [WD_CW-1:0] wd_cnt;

    rsv_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .pin_i  (csn_wdi_i),
        .fall_o (kick)
    );

    rsv_hold_timer #(.HOLD_TICKS(HOLD_TICKS)) u_hold (
        .clk       (clk),
        .rst       (rst),
        .tick_i    (tick_i),
        .restart_i (supply_low_i | wd_expire),
        .busy_o    (hold_busy)
    );

    assign rst_active = supply_low_i | hold_busy;

    rsv_wd_timer #(
        .WD_SHORT (WD_SHORT),
        .WD_MED   (WD_MED),
        .WD_LONG  (WD_LONG),
        .CW       (WD_CW)
    ) u_wd (
        .clk    (clk),
        .rst    (rst),
        .tick_i (tick_i),
        .hold_i (rst_active),
        .sel_i  (wd_sel_i),
        .kick_i (kick),
        .evt_o  (wd_evt),
        .cnt_o  (wd_cnt)
    );

    assign wd_expire = wd_evt.expire;

    rsv_cause_flag u_flag (
        .clk      (clk),
        .rst      (rst),
        .low_i    (supply_low_i),
        .expire_i (wd_expire),
        .clr_i    (flag_clr_i),
        .flag_o   (wd_flag_o)
    );

    assign sys_rst_o = drive_level(rst_active, ACTIVE_HIGH);
endmodule

// File: rtl/rsv_checker.sv
module rsv_checker #(
    parameter int WD_MAX = 20,
    parameter int CW     = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          tick_i,
    input logic          supply_low_i,
    input logic [1:0]    wd_sel_i,
    input logic          rst_active,
    input logic          wd_expire,
    input logic          wd_flag_o,
    input logic [CW-1:0] wd_cnt
);
    p_low_forces_reset_r2: assert property (@(posedge clk) disable iff (rst)
        supply_low_i |-> rst_active);

    p_off_never_expires_r4: assert property (@(posedge clk) disable iff (rst)
        (wd_sel_i == 2'b11) |-> !wd_expire);

    p_cnt_cleared_in_reset_r6: assert property (@(posedge clk) disable iff (rst)
        rst_active |=> (wd_cnt == '0));

    p_cnt_in_range_r6: assert property (@(posedge clk) disable iff (rst)
        wd_cnt < CW'(WD_MAX));

    p_expire_sets_flag_r7: assert property (@(posedge clk) disable iff (rst)
        wd_expire |=> wd_flag_o);

    p_low_clears_flag_r8: assert property (@(posedge clk) disable iff (rst)
        supply_low_i |=> !wd_flag_o);

    p_expire_on_tick_r10: assert property (@(posedge clk) disable iff (rst)
        wd_expire |-> tick_i);

    p_release_on_tick_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(rst_active) |-> $past(tick_i));
endmodule

bind rst_supervisor rsv_checker #(.WD_MAX(WD_MAX), .CW(WD_CW)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .tick_i       (tick_i),
    .supply_low_i (supply_low_i),
    .wd_sel_i     (wd_sel_i),
    .rst_active   (rst_active),
    .wd_expire    (wd_expire),
    .wd_flag_o    (wd_flag_o),
    .wd_cnt       (wd_cnt)
);

// File: tb/rst_supervisor_tb.sv
module rst_supervisor_tb;
    localparam int H  = 6;
    localparam int WS = 5;
    localparam int WM = 10;
    localparam int WL = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick;
    logic       slow = 1'b0;
    logic       tick_ph = 1'b0;
    logic       supply_low = 1'b0;
    logic       csn = 1'b1;
    logic [1:0] sel = 2'b00;
    logic       fclr = 1'b0;
    logic       sys_rst, flag, sys_rst_lo, flag_lo;

    int checks = 0;
    int fails  = 0;
    int pol_bad = 0;

    always #10 clk = ~clk;

    always @(negedge clk) tick_ph <= ~tick_ph;
    assign tick = slow ? tick_ph : 1'b1;

    rst_supervisor #(.ACTIVE_HIGH(1'b1), .HOLD_TICKS(H), .WD_SHORT(WS),
                     .WD_MED(WM), .WD_LONG(WL)) u_dut (
        .clk(clk), .rst(rst), .tick_i(tick), .supply_low_i(supply_low),
        .csn_wdi_i(csn), .wd_sel_i(sel), .flag_clr_i(fclr),
        .sys_rst_o(sys_rst), .wd_flag_o(flag));

    rst_supervisor #(.ACTIVE_HIGH(1'b0), .HOLD_TICKS(H), .WD_SHORT(WS),
                     .WD_MED(WM), .WD_LONG(WL)) u_dut_lo (
        .clk(clk), .rst(rst), .tick_i(tick), .supply_low_i(supply_low),
        .csn_wdi_i(csn), .wd_sel_i(sel), .flag_clr_i(fclr),
        .sys_rst_o(sys_rst_lo), .wd_flag_o(flag_lo));

    // R9: polarity variants must be complements at every sample
    always @(negedge clk) if (!rst && (sys_rst_lo !== ~sys_rst)) pol_bad++;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic count_on(output int n);
        n = 0;
        while (sys_rst && n < 400) begin n++; @(negedge clk); end
    endtask

    task automatic count_off(output int n);
        n = 0;
        while (!sys_rst && n < 400) begin n++; @(negedge clk); end
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog timeout actual=1 expected=0");
        summary();
    end

    initial begin
        int n;
        repeat (4) @(negedge clk);
        check(sys_rst == 1'b1, "R1 reset state", sys_rst, 1);
        check(flag == 1'b0, "R8 flag after power-on", flag, 0);
        rst = 1'b0;
        count_on(n);
        check(n == H, "R1 power-on hold", n, H);
        count_off(n);
        check(n == WS, "R3 short interval", n, WS);
        check(flag == 1'b1, "R7 flag on expiry", flag, 1);

        // R3/R6: every selection, set during the hold-off
        for (int s = 0; s < 3; s++) begin
            int exp_l;
            exp_l = (s == 0) ? WS : (s == 1) ? WM : WL;
            sel = 2'(s);
            count_on(n);
            check(n == H, "R6 hold after watchdog", n, H);
            count_off(n);
            check(n == exp_l, "R3 interval per selection", n, exp_l);
        end

        // R8: firmware clear during a released phase
        sel = 2'b10;
        count_on(n);
        repeat (2) @(negedge clk);
        fclr = 1'b1; @(negedge clk); fclr = 1'b0;
        check(flag == 1'b0, "R8 firmware clear", flag, 0);
        count_off(n);
        check(flag == 1'b1, "R7 flag set again", flag, 1);

        // R4: disabled
        sel = 2'b11;
        count_on(n);
        begin
            int k;
            k = 0;
            while (!sys_rst && k < 120) begin k++; @(negedge clk); end
            check(k == 120, "R4 disabled never resets", k, 120);
        end

        // R5: regular falling edges keep it alive
        sel = 2'b00;
        csn = 1'b1;
        begin
            int bad;
            bad = 0;
            for (int c = 0; c < 64; c++) begin
                csn = (c % 4) < 2;
                @(negedge clk);
                if (sys_rst) bad++;
            end
            check(bad == 0, "R5 restarts prevent reset", bad, 0);
        end
        csn = 1'b0;
        count_off(n);
        check(n >= 1 && n <= WS + 4, "R5 expiry after restarts stop", n, WS);

        // R5: rising edge ignored, falling edge restarts (pin low here)
        count_on(n);
        n = 0;
        while (!sys_rst && n < 400) begin
            n++;
            if (n == 2) csn = 1'b1;
            @(negedge clk);
        end
        check(n == WS, "R5 rising edge ignored", n, WS);
        count_on(n);
        n = 0;
        while (!sys_rst && n < 400) begin
            n++;
            if (n == 2) csn = 1'b0;
            @(negedge clk);
        end
        check(n == WS + 4, "R5 falling edge restart", n, WS + 4);

        // R2: low supply
        sel = 2'b11;
        count_on(n);
        repeat (3) @(negedge clk);
        supply_low = 1'b1;
        #1;
        check(sys_rst == 1'b1, "R2 immediate assert", sys_rst, 1);
        repeat (5) @(negedge clk);
        check(flag == 1'b0, "R8 low supply clears flag", flag, 0);
        check(sys_rst == 1'b1, "R2 held while low", sys_rst, 1);
        supply_low = 1'b0;
        count_on(n);
        check(n == H, "R2 hold after low supply", n, H);

        // R8: power-on clears a set flag
        sel = 2'b00;
        count_off(n);
        check(flag == 1'b1, "R7 flag before power-on", flag, 1);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check(flag == 1'b0, "R8 power-on clears flag", flag, 0);
        rst = 1'b0;
        count_on(n);
        check(n == H, "R1 second power-on", n, H);

        // R10: half-rate timebase doubles the hold-off
        sel = 2'b11;
        slow = 1'b1;
        repeat (3) @(negedge clk);
        supply_low = 1'b1;
        @(negedge clk);
        supply_low = 1'b0;
        count_on(n);
        check(n >= 2*H - 1 && n <= 2*H, "R10 counts on ticks only", n, 2*H);

        check(pol_bad == 0, "R9 polarity complement", pol_bad, 0);
        summary();
    end
endmodule